// File: doc/BRIEF.md
# Board Control Register File with Interrupt Aggregator

This block is a small memory-mapped register file for board housekeeping. A single-cycle slave port (byte address, write strobe, read strobe, 32-bit write and read data) reaches eight general scratch registers: two LED pattern words, one LED control word, a switch word, three miscellaneous control words and one miscellaneous status word. It also reaches an interrupt enable register, a sticky interrupt pending register and two card-slot status registers.

Sixteen level-sensitive interrupt lines enter the block. A line is captured into the pending register only when it is high while its enable bit is set, and the capture remains after the line falls. One combined interrupt output is high whenever any bit is both pending and enabled. Two of the lines (9 and 13 by default) also report card presence. Each is copied, inverted, into an active-low "card absent" bit of its card-slot register. Software may change only the five power and reset control bits of those registers.

The address decoder maps the byte address to one named selection: SEL_NONE, SEL_LED_A, SEL_LED_B, SEL_LED_CTL, SEL_SWITCH, SEL_MISC0, SEL_MISC1, SEL_MISC2, SEL_MISC_RD, SEL_IRQ_EN, SEL_IRQ_PEND, SEL_SLOT0 or SEL_SLOT1. The decoder is purely combinational. The only sequential transitions are register updates on the rising clock edge, with a synchronous active-high reset.

Top module: `brd_ctrl_regs`

## Requirements
- R1: After reset, all scratch registers, the enable register and the pending register read 0, both card-slot registers read 0x420 while their presence lines are low, and irq_o is low.
- R2: A pending bit is set at a clock edge where its input line is high and its enable bit (the value held before that edge) is 1. The bit then stays set after the line falls, until software writes the pending register.
- R3: irq_o is high exactly when the bitwise AND of the pending and enable registers is nonzero. It follows a write to either register one cycle after the write strobe.
- R4: Writes to the enable register (offset 0xC0) and the pending register (offset 0xD0) store the data ANDed with 0x000FEEFF. Bits 8 and 12 and bits 31:20 always read 0, and inputs 8 and 12 can never become pending.
- R5: A write to the pending register replaces its contents with the masked data. Writing 0 clears all pending bits.
- R6: When a pending register write and an enabled high input occur in the same cycle, that input's pending bit ends up set.
- R7: The scratch registers sit at offsets 0x10, 0x14, 0x40, 0x60, 0x80, 0x84, 0x88 and 0x90. Each stores and returns all 32 bits.
- R8: A read from an unmapped offset (including offsets that are not a multiple of 4) returns 0. A write to one changes no register.
- R9: Bit 5 of card-slot register 0 (offset 0xE0) is the inverse of input line 9, and bit 5 of card-slot register 1 (offset 0xE4) is the inverse of line 13. Each is sampled at every clock edge.
- R10: A write to a card-slot register changes only bits 4:0. Bit 10 (ready) and all other bits keep their values.
- R11: Read data is registered. It shows the addressed register's value from before the read edge one cycle after rd_en_i, so a read together with a write to the same register returns the old value. rdata_o is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 8 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_lines_i | input | 16 | External level interrupt lines |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The embedded assertions watch, every cycle, several properties of the block:
- pending bits stay set unless software writes the pending register;
- an enabled high line is captured even during a pending write;
- masked bits stay zero;
- presence bits follow their lines one cycle later;
- card-slot bits above the control field, other than presence, never move;
- read data is zero after idle cycles and after unmapped reads.

Some behaviours can only be shown by the bench scenarios:
- full address-map readback;
- that an unmapped write leaves every real register untouched;
- read-during-write ordering;
- the exact reset values.

The bench reaches these through its behavioural reference model, which it compares with both outputs on every clock.

// File: rtl/brd_pkg.sv
package brd_pkg;

    // Byte offsets of the mapped registers
    localparam logic [7:0] OFF_LED_A   = 8'h10;
    localparam logic [7:0] OFF_LED_B   = 8'h14;
    localparam logic [7:0] OFF_LED_CTL = 8'h40;
    localparam logic [7:0] OFF_SWITCH  = 8'h60;
    localparam logic [7:0] OFF_MISC0   = 8'h80;
    localparam logic [7:0] OFF_MISC1   = 8'h84;
    localparam logic [7:0] OFF_MISC2   = 8'h88;
    localparam logic [7:0] OFF_MISC_RD = 8'h90;
    localparam logic [7:0] OFF_IRQ_EN  = 8'hC0;
    localparam logic [7:0] OFF_IRQ_PND = 8'hD0;
    localparam logic [7:0] OFF_SLOT0   = 8'hE0;
    localparam logic [7:0] OFF_SLOT1   = 8'hE4;

    localparam int SCRATCH_N = 8;

    // Scratch selections must stay contiguous, starting at SEL_LED_A
    typedef enum logic [3:0] {
        SEL_NONE     = 4'd0,
        SEL_LED_A    = 4'd1,
        SEL_LED_B    = 4'd2,
        SEL_LED_CTL  = 4'd3,
        SEL_SWITCH   = 4'd4,
        SEL_MISC0    = 4'd5,
        SEL_MISC1    = 4'd6,
        SEL_MISC2    = 4'd7,
        SEL_MISC_RD  = 4'd8,
        SEL_IRQ_EN   = 4'd9,
        SEL_IRQ_PEND = 4'd10,
        SEL_SLOT0    = 4'd11,
        SEL_SLOT1    = 4'd12
    } brd_sel_e;

endpackage

// File: rtl/brd_addr_decode.sv
module brd_addr_decode
    import brd_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output brd_sel_e          sel_o
);

    always_comb begin
        unique case (addr_i)
            ADDR_W'(OFF_LED_A):   sel_o = SEL_LED_A;
            ADDR_W'(OFF_LED_B):   sel_o = SEL_LED_B;
            ADDR_W'(OFF_LED_CTL): sel_o = SEL_LED_CTL;
            ADDR_W'(OFF_SWITCH):  sel_o = SEL_SWITCH;
            ADDR_W'(OFF_MISC0):   sel_o = SEL_MISC0;
            ADDR_W'(OFF_MISC1):   sel_o = SEL_MISC1;
            ADDR_W'(OFF_MISC2):   sel_o = SEL_MISC2;
            ADDR_W'(OFF_MISC_RD): sel_o = SEL_MISC_RD;
            ADDR_W'(OFF_IRQ_EN):  sel_o = SEL_IRQ_EN;
            ADDR_W'(OFF_IRQ_PND): sel_o = SEL_IRQ_PEND;
            ADDR_W'(OFF_SLOT0):   sel_o = SEL_SLOT0;
            ADDR_W'(OFF_SLOT1):   sel_o = SEL_SLOT1;
            default:              sel_o = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/brd_scratch_bank.sv
module brd_scratch_bank
    import brd_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int N      = SCRATCH_N
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en_i,
    input  brd_sel_e                   sel_i,
    input  logic [DATA_W-1:0]          wdata_i,
    output logic [N-1:0][DATA_W-1:0]   regs_o
);

    for (genvar g = 0; g < N; g++) begin : g_word
        logic hit;
        assign hit = wr_en_i && (int'(sel_i) == int'(SEL_LED_A) + g);

        always_ff @(posedge clk) begin
            if (rst)
                regs_o[g] <= '0;
            else if (hit)
                regs_o[g] <= wdata_i;
        end
    end

endmodule

// File: rtl/brd_irq_agg.sv
module brd_irq_agg #(
    parameter int                NUM_IRQ = 16,
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] MASK    = 'h000F_EEFF
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] lines_i,
    input  logic               en_wr_i,
    input  logic               pend_wr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  en_o,
    output logic [DATA_W-1:0]  pend_o,
    output logic               irq_o
);

    localparam int EXT_W = DATA_W - NUM_IRQ;

    logic [DATA_W-1:0] lines_w;
    logic [DATA_W-1:0] set_w;
    logic [DATA_W-1:0] pend_base;

    assign lines_w = {{EXT_W{1'b0}}, lines_i};
    // Capture uses the enable value held before this edge
    assign set_w   = lines_w & en_o & MASK;

    always_comb begin
        pend_base = pend_wr_i ? (wdata_i & MASK) : pend_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_o   <= '0;
            pend_o <= '0;
        end else begin
            if (en_wr_i)
                en_o <= wdata_i & MASK;
            pend_o <= pend_base | set_w;   // hardware set wins over software write
        end
    end

    assign irq_o = |(pend_o & en_o);

    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (rst)
        !pend_wr_i |=> ((pend_o & $past(pend_o)) == $past(pend_o))); // R2

    AST_PEND_LATCH: assert property (@(posedge clk) disable iff (rst)
        (|set_w) |=> ((pend_o & $past(set_w)) == $past(set_w))); // R2

    AST_SET_BEATS_WRITE: assert property (@(posedge clk) disable iff (rst)
        (pend_wr_i && (|set_w)) |=> ((pend_o & $past(set_w)) != '0)); // R6

    AST_MASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
        ((en_o & ~MASK) == '0) && ((pend_o & ~MASK) == '0)); // R4

endmodule

// File: rtl/brd_slot_reg.sv
module brd_slot_reg #(
    parameter int DATA_W      = 32,
    parameter int CTRL_W      = 5,
    parameter int PRESENT_BIT = 5,
    parameter int READY_BIT   = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              present_i,
    output logic [DATA_W-1:0] q_o
);

    localparam logic [DATA_W-1:0] RESET_VAL =
        (DATA_W'(1) << READY_BIT) | (DATA_W'(1) << PRESENT_BIT);
    localparam logic [DATA_W-1:0] CTRL_MASK = (DATA_W'(1) << CTRL_W) - DATA_W'(1);
    localparam logic [DATA_W-1:0] HOLD_MASK = ~(CTRL_MASK | (DATA_W'(1) << PRESENT_BIT));

    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = q_o;
        if (wr_en_i)
            nxt = (q_o & ~CTRL_MASK) | (wdata_i & CTRL_MASK);
        nxt[PRESENT_BIT] = ~present_i;     // active-low card-absent flag
    end

    always_ff @(posedge clk) begin
        if (rst)
            q_o <= RESET_VAL;
        else
            q_o <= nxt;
    end

    AST_SLOT_PRESENT: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (q_o[PRESENT_BIT] == !$past(present_i))); // R9

    AST_SLOT_UPPER_HELD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q_o & HOLD_MASK) == ($past(q_o) & HOLD_MASK))); // R10

endmodule

// File: rtl/brd_ctrl_regs.sv
module brd_ctrl_regs
    import brd_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 32,
    parameter int                NUM_IRQ    = 16,
    parameter logic [DATA_W-1:0] IRQ_MASK   = 'h000F_EEFF,
    parameter int                SLOT0_LINE = 9,
    parameter int                SLOT1_LINE = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic               wr_en_i,
    input  logic               rd_en_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [DATA_W-1:0]  rdata_o,
    input  logic [NUM_IRQ-1:0] irq_lines_i,
    output logic               irq_o
);

    localparam int NUM_SLOT  = 2;
    localparam int SCR_IDX_W = $clog2(SCRATCH_N);

    brd_sel_e                          sel;
    logic [SCRATCH_N-1:0][DATA_W-1:0]  scratch_q;
    logic [DATA_W-1:0]                 en_q;
    logic [DATA_W-1:0]                 pend_q;
    logic [NUM_SLOT-1:0][DATA_W-1:0]   slot_q;
    logic [SCR_IDX_W-1:0]              scr_idx;
    logic [DATA_W-1:0]                 rd_val;

    brd_addr_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr_i (addr_i),
        .sel_o  (sel)
    );

    brd_scratch_bank #(.DATA_W(DATA_W), .N(SCRATCH_N)) u_scratch (
        .clk     (clk),
        .rst     (rst),
        .wr_en_i (wr_en_i),
        .sel_i   (sel),
        .wdata_i (wdata_i),
        .regs_o  (scratch_q)
    );

    brd_irq_agg #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W), .MASK(IRQ_MASK)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .lines_i   (irq_lines_i),
        .en_wr_i   (wr_en_i && (sel == SEL_IRQ_EN)),
        .pend_wr_i (wr_en_i && (sel == SEL_IRQ_PEND)),
        .wdata_i   (wdata_i),
        .en_o      (en_q),
        .pend_o    (pend_q),
        .irq_o     (irq_o)
    );

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        localparam int       LINE   = (s == 0) ? SLOT0_LINE : SLOT1_LINE;
        localparam brd_sel_e MY_SEL = (s == 0) ? SEL_SLOT0 : SEL_SLOT1;

        brd_slot_reg #(.DATA_W(DATA_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .wr_en_i   (wr_en_i && (sel == MY_SEL)),
            .wdata_i   (wdata_i),
            .present_i (irq_lines_i[LINE]),
            .q_o       (slot_q[s])
        );
    end

    assign scr_idx = SCR_IDX_W'(int'(sel) - int'(SEL_LED_A));

    always_comb begin
        unique case (sel)
            SEL_NONE:     rd_val = '0;
            SEL_IRQ_EN:   rd_val = en_q;
            SEL_IRQ_PEND: rd_val = pend_q;
            SEL_SLOT0:    rd_val = slot_q[0];
            SEL_SLOT1:    rd_val = slot_q[1];
            default:      rd_val = scratch_q[scr_idx];
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_o <= '0;
        else
            rdata_o <= rd_en_i ? rd_val : '0;
    end

    AST_IRQ_LOW_AFTER_RESET: assert property (@(posedge clk)
        rst |=> !irq_o); // R1

    AST_RD_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_en_i |=> (rdata_o == '0)); // R11

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && (sel == SEL_NONE)) |=> (rdata_o == '0)); // R8

endmodule

// File: tb/brd_ctrl_regs_tb.sv
module brd_ctrl_regs_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  tb_addr = '0;
    logic        tb_wr = 1'b0;
    logic        tb_rd = 1'b0;
    logic [31:0] tb_wd = '0;
    logic [15:0] tb_lines = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errs   = 0;
    bit done   = 1'b0;
    bit cmp_on = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    brd_ctrl_regs u_dut (
        .clk         (clk),
        .rst         (rst),
        .addr_i      (tb_addr),
        .wr_en_i     (tb_wr),
        .rd_en_i     (tb_rd),
        .wdata_i     (tb_wd),
        .rdata_o     (rdata),
        .irq_lines_i (tb_lines),
        .irq_o       (irq)
    );

    // ---------------- behavioural reference model ----------------
    localparam logic [31:0] MSK = 32'h000F_EEFF;
    logic [31:0] m_scr [8];
    logic [31:0] m_en, m_pend, m_s0, m_s1, m_rd;

    function automatic int scr_of(input logic [7:0] a);
        case (a)
            8'h10: return 0;
            8'h14: return 1;
            8'h40: return 2;
            8'h60: return 3;
            8'h80: return 4;
            8'h84: return 5;
            8'h88: return 6;
            8'h90: return 7;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (scr_of(a) >= 0) return m_scr[scr_of(a)];
        if (a == 8'hC0) return m_en;
        if (a == 8'hD0) return m_pend;
        if (a == 8'hE0) return m_s0;
        if (a == 8'hE4) return m_s1;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 8; i++) m_scr[i] = 32'h0;
            m_en = 0; m_pend = 0; m_s0 = 32'h420; m_s1 = 32'h420; m_rd = 0;
        end else begin
            logic [31:0] old_en;
            m_rd   = tb_rd ? m_read(tb_addr) : 32'h0;
            old_en = m_en;
            if (tb_wr) begin
                if (scr_of(tb_addr) >= 0) m_scr[scr_of(tb_addr)] = tb_wd;
                else if (tb_addr == 8'hC0) m_en = tb_wd & MSK;
                else if (tb_addr == 8'hD0) m_pend = tb_wd & MSK;
                else if (tb_addr == 8'hE0) m_s0 = (m_s0 & ~32'h1F) | (tb_wd & 32'h1F);
                else if (tb_addr == 8'hE4) m_s1 = (m_s1 & ~32'h1F) | (tb_wd & 32'h1F);
            end
            m_pend = m_pend | ({16'h0, tb_lines} & old_en & MSK);
            m_s0[5] = ~tb_lines[9];
            m_s1[5] = ~tb_lines[13];
        end
    end

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model (R3 irq, R11 read data)
    always @(negedge clk) begin
        if (cmp_on) begin
            check({31'b0, irq}, {31'b0, |(m_pend & m_en)}, "R3 model irq");
            check(rdata, m_rd, "R11 model rdata");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
        tb_wr = w; tb_rd = r; tb_addr = a; tb_wd = d;
        @(negedge clk);
        tb_wr = 1'b0; tb_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b0, a, d);
    endtask

    task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cyc(1'b0, 1'b1, a, 32'h0);
        check(rdata, exp, tag);
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errs, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;
        @(negedge clk);

        // R1 reset state
        check({31'b0, irq}, 32'h0, "R1 irq after reset");
        rd_expect(8'h10, 32'h0, "R1 scratch reset");
        rd_expect(8'hC0, 32'h0, "R1 enable reset");
        rd_expect(8'hD0, 32'h0, "R1 pending reset");
        rd_expect(8'hE0, 32'h420, "R1 slot0 reset");
        rd_expect(8'hE4, 32'h420, "R1 slot1 reset");

        // R7 scratch map
        wr(8'h10, 32'hDEADBEEF); wr(8'h14, 32'h01234567); wr(8'h40, 32'hA5A5A5A5);
        wr(8'h60, 32'h5A5A5A5A); wr(8'h80, 32'hFFFF0000); wr(8'h84, 32'h0000FFFF);
        wr(8'h88, 32'h80000001); wr(8'h90, 32'h13579BDF);
        rd_expect(8'h10, 32'hDEADBEEF, "R7 led a");
        rd_expect(8'h14, 32'h01234567, "R7 led b");
        rd_expect(8'h40, 32'hA5A5A5A5, "R7 led ctl");
        rd_expect(8'h60, 32'h5A5A5A5A, "R7 switch");
        rd_expect(8'h80, 32'hFFFF0000, "R7 misc0");
        rd_expect(8'h84, 32'h0000FFFF, "R7 misc1");
        rd_expect(8'h88, 32'h80000001, "R7 misc2");
        rd_expect(8'h90, 32'h13579BDF, "R7 misc rd");

        // R8 unmapped
        rd_expect(8'h11, 32'h0, "R8 misaligned read");
        wr(8'h44, 32'hFFFFFFFF);
        wr(8'h12, 32'hFFFFFFFF);
        rd_expect(8'h44, 32'h0, "R8 unmapped read");
        rd_expect(8'h40, 32'hA5A5A5A5, "R8 neighbour untouched");
        rd_expect(8'h10, 32'hDEADBEEF, "R8 aligned neighbour untouched");

        // R4 / R3 / R5 masks and direct replace
        wr(8'hC0, 32'hFFFFFFFF);
        rd_expect(8'hC0, 32'h000FEEFF, "R4 enable mask");
        wr(8'hD0, 32'hFFFFFFFF);
        check({31'b0, irq}, 32'h1, "R3 irq after pending write");
        rd_expect(8'hD0, 32'h000FEEFF, "R4 pending mask");
        wr(8'hD0, 32'h0);
        check({31'b0, irq}, 32'h0, "R5 irq after clear");
        rd_expect(8'hD0, 32'h0, "R5 pending replaced");

        // R2 latch only while enabled, sticky
        wr(8'hC0, 32'h4);
        tb_lines = 16'h0008; idle(); tb_lines = 16'h0;
        rd_expect(8'hD0, 32'h0, "R2 disabled line ignored");
        tb_lines = 16'h0004; idle(); tb_lines = 16'h0;
        idle();
        rd_expect(8'hD0, 32'h4, "R2 sticky after fall");
        check({31'b0, irq}, 32'h1, "R3 irq pending enabled");
        wr(8'hC0, 32'h0);
        check({31'b0, irq}, 32'h0, "R3 irq masked by enable");
        rd_expect(8'hD0, 32'h4, "R2 pending kept when disabled");
        wr(8'hC0, 32'h4);
        check({31'b0, irq}, 32'h1, "R3 irq re-enabled");
        wr(8'hD0, 32'h0);

        // R6 hardware set wins over software clear
        wr(8'hC0, 32'h2);
        tb_lines = 16'h0002; wr(8'hD0, 32'h0); tb_lines = 16'h0;
        rd_expect(8'hD0, 32'h2, "R6 set beats write");
        wr(8'hD0, 32'h0);
        rd_expect(8'hD0, 32'h0, "R5 clear with line low");

        // R4 bits 8 and 12 cannot latch
        wr(8'hC0, 32'h1100);
        rd_expect(8'hC0, 32'h0, "R4 enable bits 8/12 dropped");
        tb_lines = 16'h1100; idle(); tb_lines = 16'h0;
        rd_expect(8'hD0, 32'h0, "R4 lines 8/12 never pending");

        // R9 presence mirror
        wr(8'hC0, 32'h0);
        tb_lines = 16'h0200; idle();
        rd_expect(8'hE0, 32'h400, "R9 slot0 card present");
        rd_expect(8'hE4, 32'h420, "R9 slot1 absent");
        tb_lines = 16'h2000; idle();
        rd_expect(8'hE4, 32'h400, "R9 slot1 card present");
        rd_expect(8'hE0, 32'h420, "R9 slot0 absent again");
        tb_lines = 16'h0; idle();
        rd_expect(8'hE4, 32'h420, "R9 slot1 absent again");

        // R10 card-slot write mask
        wr(8'hE0, 32'hFFFFFFFF);
        rd_expect(8'hE0, 32'h43F, "R10 only low bits written");
        wr(8'hE4, 32'hFFFFFFE0);
        rd_expect(8'hE4, 32'h420, "R10 upper bits ignored");

        // R11 read timing and read-during-write
        wr(8'h10, 32'h11111111);
        cyc(1'b1, 1'b1, 8'h10, 32'h22222222);
        check(rdata, 32'h11111111, "R11 read returns old value");
        idle();
        check(rdata, 32'h0, "R11 zero after idle");
        rd_expect(8'h10, 32'h22222222, "R11 new value visible");

        idle();
        done = 1'b1;
        report();
        $finish;
    end

endmodule